// File: doc/BRIEF.md
# Receive Byte Queue with Threshold and Idle Interrupts

This block is the receive-side buffer of a serial port. A deserializer hands it one byte at a time with a single-cycle strobe. The block keeps up to sixteen bytes in arrival order, and the host drains them through a read strobe. The oldest stored byte is always visible on the read-data output, so a read strobe both consumes that byte and moves the next one forward.

To cut the number of host interrupts, the block requests service only when the fill level reaches a programmable trigger point of 1, 4, 8 or 14 bytes. A small number of bytes can still be left behind when the sender goes quiet. To cover that case, a watchdog counts character-time ticks while the queue holds fewer bytes than the trigger point. After four idle character times it raises a timeout request so that the host collects the remainder. A byte that arrives with no room left is dropped and recorded in a sticky overrun flag. The interrupt request is the OR of the threshold, timeout and overrun conditions. A queue-clear input returns everything to the empty state.

Top module: `rx_queue_irq`

## Requirements
- R1: The queue stores up to 16 bytes in arrival order. `rdData` shows the oldest stored byte, and an accepted read removes it. `fillCount` gives the number of stored bytes (0 to 16), and `dataReady` is high exactly when `fillCount` is nonzero. All of these update at the clock edge that samples the strobe.
- R2: The 2-bit `levelSel` field chooses the trigger point: 2'b00 selects 1 byte, 2'b01 selects 4, 2'b10 selects 8 and 2'b11 selects 14.
- R3: The threshold condition is true while `fillCount` is at or above the selected trigger point, and false once the count drops below it.
- R4: While the count is between 1 and one less than the trigger point, four `charTick` pulses with no accepted write or read set `timeoutFlag`. An accepted write or read restarts this count from zero.
- R5: `timeoutFlag` clears on an accepted read and whenever the queue is empty.
- R6: A write strobe when 16 bytes are stored and no read is made in the same cycle drops the incoming byte. The stored bytes and the count are left unchanged, and `overrunFlag` is high after that edge.
- R7: `overrunFlag` stays high, even after the queue drains, until a one-cycle `statusAck` pulse clears it.
- R8: A write and a read in the same cycle with the queue full are both accepted. The count stays at 16, no overrun is flagged, and the new byte becomes the newest entry.
- R9: A read strobe on an empty queue is ignored, and the count stays at 0.
- R10: `fifoClear` takes priority over all other strobes. After the edge that samples it, the count is 0 and `overrunFlag`, `timeoutFlag` and `irq` are all low.
- R11: `irq` equals the OR of the threshold condition, `timeoutFlag` and `overrunFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrStrobe | input | 1 | Received byte is valid this cycle |
| wrData | input | 8 | Received byte |
| rdStrobe | input | 1 | Host consumes the oldest byte |
| levelSel | input | 2 | Trigger point select |
| charTick | input | 1 | One-cycle pulse per character time |
| fifoClear | input | 1 | Empty the queue and clear flags |
| statusAck | input | 1 | Clear the overrun flag |
| rdData | output | 8 | Oldest stored byte |
| fillCount | output | 5 | Number of stored bytes |
| dataReady | output | 1 | At least one byte is stored |
| overrunFlag | output | 1 | Sticky byte-lost indication |
| timeoutFlag | output | 1 | Idle timeout indication |
| irq | output | 1 | Interrupt request |

## Verification
The count, the head byte and both flags are registered. Each one is due exactly one clock edge after the strobe that causes it. `irq` is combinational from that registered state, so it is due at the same time. The bench drives every strobe one time unit after a rising edge and samples one time unit after the next rising edge, so each check reads the result of exactly one edge. Timeout checks count the tick-bearing cycles individually: the check after the third tick expects the flag low, and the check after the fourth expects it high.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    TRIG_ONE      = 2'b00,
    TRIG_FOUR     = 2'b01,
    TRIG_EIGHT    = 2'b10,
    TRIG_FOURTEEN = 2'b11
  } trigSel_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } rxqStrobe_t;

endpackage

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxqStrobe_t       strobe,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] headData,
  output logic [CW-1:0]    count,
  output logic             notEmpty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrPtr;
  logic [PW-1:0]    rdPtr;

  always_ff @(posedge clk) begin
    if (strobe.push && !strobe.clear) begin
      mem[wrPtr] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strobe.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + PW'(1);
      if (strobe.pop)  rdPtr <= rdPtr + PW'(1);
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign headData = mem[rdPtr];
  assign notEmpty = (count != '0);

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int TIMEOUT_CHARS = 4,
  parameter int LEVEL_A       = 1,
  parameter int LEVEL_B       = 4,
  parameter int LEVEL_C       = 8,
  parameter int LEVEL_D       = 14,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int TW = $clog2(TIMEOUT_CHARS) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrStrobe,
  input  logic          rdStrobe,
  input  logic          charTick,
  input  logic          statusAck,
  input  logic          fifoClear,
  input  logic [1:0]    levelSel,
  input  logic [CW-1:0] count,
  output rxqStrobe_t    strobe,
  output logic          overrunFlag,
  output logic          timeoutFlag,
  output logic          irq
);

  logic          isFull;
  logic          isEmpty;
  logic          popOk;
  logic          pushOk;
  logic          overEvent;
  logic [CW-1:0] selLevel;
  logic          threshHit;
  logic          timerArmed;
  logic          timerExpire;
  logic [TW-1:0] tickCnt;

  assign isFull  = (count == CW'(DEPTH));
  assign isEmpty = (count == '0);

  always_comb begin
    case (trigSel_e'(levelSel))
      TRIG_ONE:      selLevel = CW'(LEVEL_A);
      TRIG_FOUR:     selLevel = CW'(LEVEL_B);
      TRIG_EIGHT:    selLevel = CW'(LEVEL_C);
      default:       selLevel = CW'(LEVEL_D);
    endcase
  end

  assign popOk     = rdStrobe && !isEmpty && !fifoClear;
  assign pushOk    = wrStrobe && (!isFull || popOk) && !fifoClear;
  assign overEvent = wrStrobe && isFull && !popOk && !fifoClear;

  always_comb begin
    strobe.push  = pushOk;
    strobe.pop   = popOk;
    strobe.clear = fifoClear;
  end

  assign threshHit   = (count >= selLevel);
  assign timerArmed  = !isEmpty && (count < selLevel) && !timeoutFlag;
  assign timerExpire = timerArmed && charTick && (tickCnt == TW'(TIMEOUT_CHARS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (fifoClear || pushOk || popOk || isEmpty || timerExpire) begin
      tickCnt <= '0;
    end else if (timerArmed && charTick) begin
      tickCnt <= tickCnt + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeoutFlag <= 1'b0;
    end else if (fifoClear || popOk || isEmpty) begin
      timeoutFlag <= 1'b0;
    end else if (timerExpire) begin
      timeoutFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrunFlag <= 1'b0;
    end else if (fifoClear) begin
      overrunFlag <= 1'b0;
    end else if (overEvent) begin
      overrunFlag <= 1'b1;
    end else if (statusAck) begin
      overrunFlag <= 1'b0;
    end
  end

  assign irq = threshHit || timeoutFlag || overrunFlag;

endmodule

// File: rtl/rx_queue_irq.sv
module rx_queue_irq
  import rxq_pkg::*;
#(
  parameter int WIDTH         = 8,
  parameter int DEPTH         = 16,
  parameter int TIMEOUT_CHARS = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrStrobe,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdStrobe,
  input  logic [1:0]       levelSel,
  input  logic             charTick,
  input  logic             fifoClear,
  input  logic             statusAck,
  output logic [WIDTH-1:0] rdData,
  output logic [CW-1:0]    fillCount,
  output logic             dataReady,
  output logic             overrunFlag,
  output logic             timeoutFlag,
  output logic             irq
);

  rxqStrobe_t strobe;

  rxq_ctrl #(
    .DEPTH(DEPTH),
    .TIMEOUT_CHARS(TIMEOUT_CHARS)
  ) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .wrStrobe(wrStrobe),
    .rdStrobe(rdStrobe),
    .charTick(charTick),
    .statusAck(statusAck),
    .fifoClear(fifoClear),
    .levelSel(levelSel),
    .count(fillCount),
    .strobe(strobe),
    .overrunFlag(overrunFlag),
    .timeoutFlag(timeoutFlag),
    .irq(irq)
  );

  rxq_datapath #(
    .WIDTH(WIDTH),
    .DEPTH(DEPTH)
  ) uData (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .wrData(wrData),
    .headData(rdData),
    .count(fillCount),
    .notEmpty(dataReady)
  );

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrStrobe,
  input logic          rdStrobe,
  input logic          fifoClear,
  input logic          statusAck,
  input logic [1:0]    levelSel,
  input logic [CW-1:0] fillCount,
  input logic          overrunFlag,
  input logic          timeoutFlag,
  input logic          irq
);

  logic [CW-1:0] expLevel;
  always_comb begin
    case (levelSel)
      2'b00:   expLevel = CW'(1);
      2'b01:   expLevel = CW'(4);
      2'b10:   expLevel = CW'(8);
      default: expLevel = CW'(14);
    endcase
  end

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CW'(DEPTH)); // R1
  AST_THRESH_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount >= expLevel) |-> irq); // R3
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount < expLevel && !timeoutFlag && !overrunFlag) |-> !irq); // R11
  AST_NO_TIMEOUT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == '0) |-> !timeoutFlag); // R5
  AST_OVERRUN_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !rdStrobe && !fifoClear && fillCount == CW'(DEPTH)) |=> overrunFlag); // R6
  AST_OVERRUN_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !rdStrobe && !fifoClear && fillCount == CW'(DEPTH)) |=> fillCount == CW'(DEPTH)); // R6
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrunFlag && !statusAck && !fifoClear) |=> overrunFlag); // R7
  AST_FULL_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && rdStrobe && !fifoClear && fillCount == CW'(DEPTH) && !overrunFlag)
      |=> (fillCount == CW'(DEPTH) && !overrunFlag)); // R8
  AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !wrStrobe && !fifoClear && fillCount == '0) |=> fillCount == '0); // R9
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rstN)
    fifoClear |=> (fillCount == '0 && !overrunFlag && !timeoutFlag && !irq)); // R10

endmodule

bind rx_queue_irq rxq_checker #(.DEPTH(DEPTH)) uChk (
  .clk(clk),
  .rstN(rstN),
  .wrStrobe(wrStrobe),
  .rdStrobe(rdStrobe),
  .fifoClear(fifoClear),
  .statusAck(statusAck),
  .levelSel(levelSel),
  .fillCount(fillCount),
  .overrunFlag(overrunFlag),
  .timeoutFlag(timeoutFlag),
  .irq(irq)
);

// File: tb/tb_rx_queue_irq.sv
module tb_rx_queue_irq;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 5000;
  localparam int NUM_VEC = 10;

  // Row layout: [24] write, [23] read, [22:15] data, [14:10] expected count,
  // [9:2] expected head, [1] check head, [0] expected irq (trigger point 4)
  localparam logic [24:0] VEC [NUM_VEC] = '{
    {1'b1, 1'b0, 8'h11, 5'd1, 8'h11, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'h22, 5'd2, 8'h11, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'h33, 5'd3, 8'h11, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'h44, 5'd4, 8'h11, 1'b1, 1'b1},
    {1'b1, 1'b1, 8'h55, 5'd4, 8'h22, 1'b1, 1'b1},
    {1'b0, 1'b1, 8'h00, 5'd3, 8'h33, 1'b1, 1'b0},
    {1'b0, 1'b1, 8'h00, 5'd2, 8'h44, 1'b1, 1'b0},
    {1'b0, 1'b1, 8'h00, 5'd1, 8'h55, 1'b1, 1'b0},
    {1'b0, 1'b1, 8'h00, 5'd0, 8'h00, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h00, 5'd0, 8'h00, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       rdStrobe = 1'b0;
  logic [1:0] levelSel = 2'b01;
  logic       charTick = 1'b0;
  logic       fifoClear = 1'b0;
  logic       statusAck = 1'b0;
  logic [7:0] rdData;
  logic [4:0] fillCount;
  logic       dataReady;
  logic       overrunFlag;
  logic       timeoutFlag;
  logic       irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  rx_queue_irq dut (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrData(wrData),
    .rdStrobe(rdStrobe), .levelSel(levelSel), .charTick(charTick),
    .fifoClear(fifoClear), .statusAck(statusAck), .rdData(rdData),
    .fillCount(fillCount), .dataReady(dataReady), .overrunFlag(overrunFlag),
    .timeoutFlag(timeoutFlag), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    wrStrobe = 1'b0;
    rdStrobe = 1'b0;
    charTick = 1'b0;
    fifoClear = 1'b0;
    statusAck = 1'b0;
  endtask

  task automatic pushByte(input logic [7:0] b);
    wrStrobe = 1'b1;
    wrData = b;
    step();
  endtask

  task automatic popByte();
    rdStrobe = 1'b1;
    step();
  endtask

  task automatic tick();
    charTick = 1'b1;
    step();
  endtask

  task automatic clearQueue();
    fifoClear = 1'b1;
    step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    step();

    check("R1 reset count", fillCount, 0);
    check("R1 reset dataReady", dataReady, 0);
    check("R11 reset irq", irq, 0);
    check("R7 reset overrun", overrunFlag, 0);

    // Vector table, trigger point 4
    levelSel = 2'b01;
    for (int i = 0; i < NUM_VEC; i++) begin
      wrStrobe = VEC[i][24];
      rdStrobe = VEC[i][23];
      wrData   = VEC[i][22:15];
      step();
      check($sformatf("R1 vec%0d count", i), fillCount, VEC[i][14:10]);
      check($sformatf("R1 vec%0d dataReady", i), dataReady, VEC[i][14:10] != 0);
      if (VEC[i][1]) check($sformatf("R1 vec%0d head", i), rdData, VEC[i][9:2]);
      check($sformatf("R3 vec%0d irq", i), irq, VEC[i][0]);
    end
    check("R9 empty read count", fillCount, 0);

    // R2 trigger point encodings
    clearQueue();
    for (int i = 0; i < 7; i++) pushByte(8'(i));
    levelSel = 2'b10;
    #1;
    check("R2 level 8 at 7 bytes", irq, 0);
    pushByte(8'h07);
    check("R2 level 8 at 8 bytes", irq, 1);
    levelSel = 2'b11;
    #1;
    check("R2 level 14 at 8 bytes", irq, 0);
    for (int i = 8; i < 13; i++) pushByte(8'(i));
    check("R2 level 14 at 13 bytes", irq, 0);
    pushByte(8'h0D);
    check("R2 level 14 at 14 bytes", irq, 1);
    clearQueue();
    levelSel = 2'b00;
    #1;
    check("R2 level 1 empty", irq, 0);
    pushByte(8'hA0);
    check("R2 level 1 at 1 byte", irq, 1);

    // R4 idle timeout
    clearQueue();
    levelSel = 2'b01;
    pushByte(8'hB0);
    pushByte(8'hB1);
    tick(); tick(); tick();
    check("R4 after three ticks", timeoutFlag, 0);
    check("R4 irq quiet before timeout", irq, 0);
    tick();
    check("R4 after four ticks", timeoutFlag, 1);
    check("R11 irq from timeout", irq, 1);
    popByte();
    check("R5 read clears timeout", timeoutFlag, 0);
    check("R5 count after read", fillCount, 1);

    // R4 restart on write
    clearQueue();
    pushByte(8'hC0);
    tick(); tick(); tick();
    pushByte(8'hC1);
    tick(); tick(); tick();
    check("R4 restart by write", timeoutFlag, 0);
    tick();
    check("R4 expiry after restart", timeoutFlag, 1);

    // R10 clear with a timeout pending and a write in the same cycle
    wrStrobe = 1'b1;
    wrData = 8'hDD;
    fifoClear = 1'b1;
    step();
    check("R10 clear count", fillCount, 0);
    check("R10 clear timeout", timeoutFlag, 0);
    check("R10 clear irq", irq, 0);

    // R6 overrun: byte dropped, contents intact
    levelSel = 2'b11;
    for (int i = 0; i < 16; i++) pushByte(8'h60 + 8'(i));
    check("R6 full count", fillCount, 16);
    pushByte(8'hEE);
    check("R6 overrun set", overrunFlag, 1);
    check("R6 count unchanged", fillCount, 16);
    for (int i = 0; i < 16; i++) begin
      check($sformatf("R6 stored byte %0d", i), rdData, 8'h60 + 8'(i));
      popByte();
    end
    check("R6 drained", fillCount, 0);
    check("R7 overrun sticky after drain", overrunFlag, 1);
    check("R11 irq from overrun alone", irq, 1);
    statusAck = 1'b1;
    step();
    check("R7 ack clears overrun", overrunFlag, 0);
    check("R11 irq low after ack", irq, 0);

    // R8 write and read together at full
    for (int i = 0; i < 16; i++) pushByte(8'h40 + 8'(i));
    wrStrobe = 1'b1;
    rdStrobe = 1'b1;
    wrData = 8'h99;
    step();
    check("R8 count stays full", fillCount, 16);
    check("R8 no overrun", overrunFlag, 0);
    check("R8 head advanced", rdData, 8'h41);
    for (int i = 0; i < 15; i++) popByte();
    check("R8 new byte is newest", rdData, 8'h99);
    check("R8 one left", fillCount, 1);

    // R10 clear from full with overrun
    for (int i = 0; i < 15; i++) pushByte(8'(i));
    pushByte(8'hFF);
    check("R6 overrun again", overrunFlag, 1);
    clearQueue();
    check("R10 clear count from full", fillCount, 0);
    check("R10 clear overrun", overrunFlag, 0);
    check("R10 clear irq from full", irq, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG_CYCLES; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule